// File: doc/BRIEF.md
# Strided Tile Address Generator

This block turns a stored two-dimensional tile descriptor into a stream of memory requests. Software, or a neighbouring controller, fills one of four numbered descriptor slots through a simple register-write port. A slot records where the tile sits in global memory, where it goes in the local scratchpad, how many rows and elements per row it has, the element size, the source row stride and whether each scratchpad row gets a spare padding column. A single ignite command naming a slot then walks the whole tile. For every chunk of at most one cache line (128 bytes) the block offers a request that carries the global address, the scratchpad address and the byte count.

Requests use a valid/ready handshake toward the memory side. When the last chunk of the tile has been taken, the block raises a one-cycle done pulse tagged with the slot index. Only one tile is walked at a time. An ignite that arrives while a walk is running is dropped, and a sticky error flag records it. The descriptor is copied at ignite, so a slot can be rewritten for the next tile while the current one is still being walked.

Top module: `tile_agen`

## Requirements
- R1: After reset, req_valid, done_pulse and err_flag are all low.
- R2: A write with cfg_we high stores cfg_wdata into the slot given by cfg_slot and the field given by cfg_field. The field codes are: 0 global base, 1 scratchpad base, 2 tile height in rows, 3 tile width in elements, 4 row stride in elements, 5 element-size code, 6 padding flag. Element-size codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes.
- R3: go_valid is sampled at a clock edge while idle, for a tile with non-zero height and width. One cycle later req_valid is high, with req_gaddr equal to the global base and req_saddr equal to the scratchpad base.
- R4: Within a row, consecutive requests advance both addresses by 128 and carry req_bytes = 128. The last request of a row carries the remaining bytes of the row (1 to 128), so no request spans two rows.
- R5: At each new row, the global row start advances by stride × element size. With padding off, the scratchpad row start advances by width × element size.
- R6: With padding on, the scratchpad row start advances by (width + 1) × element size. The byte counts are unchanged.
- R7: While req_valid is high and req_ready is low, req_valid, req_gaddr, req_saddr and req_bytes hold their values.
- R8: The cycle after the final request of a tile is accepted, done_pulse is high for exactly one cycle, done_slot equals the ignited slot, and req_valid is low.
- R9: go_valid while a walk is running is ignored, so the running request stream continues unchanged. It sets err_flag one cycle later, and err_flag stays high until reset.
- R10: Configuration writes made during a walk do not change the running walk. The next ignite of that slot uses the new values.
- R11: Igniting a slot whose height or width is zero issues no request and raises done_pulse with that slot index on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_slot | input | 2 | Slot written |
| cfg_field | input | 3 | Field code written (see R2) |
| cfg_wdata | input | 32 | Field value |
| go_valid | input | 1 | Ignite command |
| go_slot | input | 2 | Slot to walk |
| req_valid | output | 1 | Request offered |
| req_ready | input | 1 | Request taken this cycle |
| req_gaddr | output | 32 | Global-memory address of the chunk |
| req_saddr | output | 32 | Scratchpad address of the chunk |
| req_bytes | output | 8 | Chunk length in bytes |
| done_pulse | output | 1 | One-cycle tile completion |
| done_slot | output | 2 | Slot that completed |
| err_flag | output | 1 | Sticky ignite-while-busy error |

## Verification
The bench aims at rows whose byte length is an exact multiple of the line size and at rows one element beyond it. A design that mishandles these either issues an empty trailing chunk or lets a chunk run into the next row. Padding and element-size codes are mixed at random. A wrong row pitch then shows up as a scratchpad address that drifts by one element per row, and a wrong stride scaling as misplaced global rows. The consumer stalls at random, so a design that moves its request fields during a stall produces mismatches. An ignite and a descriptor rewrite are injected in the middle of a walk; a design that accepts the ignite or reads the live slot corrupts the remaining stream. Empty tiles check that completion is still signalled without any request.

// File: rtl/tile_agen_pkg.sv
`timescale 1ns/1ps
package tile_agen_pkg;
  localparam int ADDR_W  = 32;
  localparam int DIM_W   = 12;
  localparam int FIELD_W = 3;

  typedef enum logic [FIELD_W-1:0] {
    FLD_GBASE  = 3'd0,
    FLD_SBASE  = 3'd1,
    FLD_HEIGHT = 3'd2,
    FLD_WIDTH  = 3'd3,
    FLD_STRIDE = 3'd4,
    FLD_ESIZE  = 3'd5,
    FLD_PAD    = 3'd6
  } field_e;

  typedef struct packed {
    logic [ADDR_W-1:0] gbase;
    logic [ADDR_W-1:0] sbase;
    logic [DIM_W-1:0]  height;
    logic [DIM_W-1:0]  width;
    logic [DIM_W-1:0]  stride;
    logic [1:0]        esz;
    logic              pad;
  } tile_desc_t;
endpackage

// File: rtl/tile_desc_bank.sv
`timescale 1ns/1ps
module tile_desc_bank
  import tile_agen_pkg::*;
#(
  parameter int SLOTS  = 4,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [SLOT_W-1:0]  wr_slot,
  input  logic [FIELD_W-1:0] wr_field,
  input  logic [ADDR_W-1:0]  wr_data,
  input  logic [SLOT_W-1:0]  rd_slot,
  output tile_desc_t         rd_desc
);
  tile_desc_t slot_q [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    tile_desc_t d_next;
    logic       hit;

    assign hit = wr_en && (wr_slot == SLOT_W'(g));

    always_comb begin
      d_next = slot_q[g];
      case (field_e'(wr_field))
        FLD_GBASE:  d_next.gbase  = wr_data;
        FLD_SBASE:  d_next.sbase  = wr_data;
        FLD_HEIGHT: d_next.height = wr_data[DIM_W-1:0];
        FLD_WIDTH:  d_next.width  = wr_data[DIM_W-1:0];
        FLD_STRIDE: d_next.stride = wr_data[DIM_W-1:0];
        FLD_ESIZE:  d_next.esz    = wr_data[1:0];
        FLD_PAD:    d_next.pad    = wr_data[0];
        default:    d_next = slot_q[g];
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   slot_q[g] <= '0;
      else if (hit) slot_q[g] <= d_next;
    end
  end

  assign rd_desc = slot_q[rd_slot];
endmodule

// File: rtl/tile_walker.sv
`timescale 1ns/1ps
module tile_walker
  import tile_agen_pkg::*;
#(
  parameter int SLOT_W     = 2,
  parameter int LINE_BYTES = 128,
  parameter int CNT_W      = $clog2(LINE_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SLOT_W-1:0] start_slot,
  input  tile_desc_t        desc,
  output logic              busy,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_gaddr,
  output logic [ADDR_W-1:0] req_saddr,
  output logic [CNT_W-1:0]  req_bytes,
  output logic              done_pulse,
  output logic [SLOT_W-1:0] done_slot
);
  localparam int OFF_W = DIM_W + 4;

  logic              busy_q, busy_d;
  logic [SLOT_W-1:0] slot_q, slot_d, dslot_q, dslot_d;
  logic [ADDR_W-1:0] grow_q, grow_d, srow_q, srow_d;
  logic [ADDR_W-1:0] gstep_q, gstep_d, spitch_q, spitch_d;
  logic [OFF_W-1:0]  off_q, off_d, rowb_q, rowb_d, remain;
  logic [DIM_W-1:0]  rows_q, rows_d;
  logic              done_q, done_d;
  logic              row_end, accept, empty;

  assign remain  = rowb_q - off_q;
  assign row_end = remain <= OFF_W'(LINE_BYTES);
  assign accept  = busy_q && req_ready;
  assign empty   = (desc.height == '0) || (desc.width == '0);

  always_comb begin
    busy_d = busy_q;  slot_d = slot_q;  dslot_d = dslot_q;
    grow_d = grow_q;  srow_d = srow_q;  gstep_d = gstep_q;
    spitch_d = spitch_q; off_d = off_q; rowb_d = rowb_q; rows_d = rows_q;
    done_d = 1'b0;
    if (start) begin
      busy_d   = !empty;
      slot_d   = start_slot;
      dslot_d  = start_slot;
      done_d   = empty;
      grow_d   = desc.gbase;
      srow_d   = desc.sbase;
      off_d    = '0;
      rows_d   = desc.height;
      rowb_d   = OFF_W'(desc.width) << desc.esz;
      gstep_d  = ADDR_W'(desc.stride) << desc.esz;
      spitch_d = (ADDR_W'(desc.width) + ADDR_W'(desc.pad)) << desc.esz;
    end else if (accept) begin
      if (row_end) begin
        off_d  = '0;
        grow_d = grow_q + gstep_q;
        srow_d = srow_q + spitch_q;
        rows_d = rows_q - DIM_W'(1);
        if (rows_q == DIM_W'(1)) begin
          busy_d  = 1'b0;
          done_d  = 1'b1;
          dslot_d = slot_q;
        end
      end else begin
        off_d = off_q + OFF_W'(LINE_BYTES);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; slot_q <= '0; dslot_q <= '0; done_q <= 1'b0;
      grow_q <= '0; srow_q <= '0; gstep_q <= '0; spitch_q <= '0;
      off_q <= '0; rowb_q <= '0; rows_q <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      if (start || accept) begin
        slot_q <= slot_d; dslot_q <= dslot_d;
        grow_q <= grow_d; srow_q <= srow_d; gstep_q <= gstep_d;
        spitch_q <= spitch_d; off_q <= off_d; rowb_q <= rowb_d; rows_q <= rows_d;
      end
    end
  end

  assign busy       = busy_q;
  assign req_valid  = busy_q;
  assign req_gaddr  = grow_q + ADDR_W'(off_q);
  assign req_saddr  = srow_q + ADDR_W'(off_q);
  assign req_bytes  = row_end ? CNT_W'(remain) : CNT_W'(LINE_BYTES);
  assign done_pulse = done_q;
  assign done_slot  = dslot_q;

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_gaddr) && $stable(req_saddr) && $stable(req_bytes));
  // R4
  chunk_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_bytes != '0) && (req_bytes <= CNT_W'(LINE_BYTES)));
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> !req_valid);
  // R9
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/tile_agen.sv
`timescale 1ns/1ps
module tile_agen
  import tile_agen_pkg::*;
#(
  parameter int SLOTS      = 4,
  parameter int SLOT_W     = $clog2(SLOTS),
  parameter int LINE_BYTES = 128,
  parameter int CNT_W      = $clog2(LINE_BYTES) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [SLOT_W-1:0]  cfg_slot,
  input  logic [FIELD_W-1:0] cfg_field,
  input  logic [ADDR_W-1:0]  cfg_wdata,
  input  logic               go_valid,
  input  logic [SLOT_W-1:0]  go_slot,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [ADDR_W-1:0]  req_gaddr,
  output logic [ADDR_W-1:0]  req_saddr,
  output logic [CNT_W-1:0]   req_bytes,
  output logic               done_pulse,
  output logic [SLOT_W-1:0]  done_slot,
  output logic               err_flag
);
  tile_desc_t sel_desc;
  logic       busy, start, err_q, err_d;

  assign start = go_valid && !busy;
  assign err_d = err_q || (go_valid && busy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end
  assign err_flag = err_q;

  tile_desc_bank #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_slot(cfg_slot),
    .wr_field(cfg_field), .wr_data(cfg_wdata), .rd_slot(go_slot), .rd_desc(sel_desc)
  );

  tile_walker #(.SLOT_W(SLOT_W), .LINE_BYTES(LINE_BYTES), .CNT_W(CNT_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(start), .start_slot(go_slot), .desc(sel_desc),
    .busy(busy), .req_valid(req_valid), .req_ready(req_ready),
    .req_gaddr(req_gaddr), .req_saddr(req_saddr), .req_bytes(req_bytes),
    .done_pulse(done_pulse), .done_slot(done_slot)
  );

  // R9
  busy_ignite_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_valid && req_valid |=> err_flag);
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);
  // R3
  ignite_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_valid && !req_valid |=> req_valid || done_pulse);
endmodule

// File: tb/tile_agen_bench.sv
`timescale 1ns/1ps
module tile_agen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_slot = '0;
  logic [2:0]  cfg_field = '0;
  logic [31:0] cfg_wdata = '0;
  logic        go_valid = 1'b0;
  logic [1:0]  go_slot = '0;
  logic        req_ready = 1'b0;
  logic        req_valid, done_pulse, err_flag;
  logic [31:0] req_gaddr, req_saddr;
  logic [7:0]  req_bytes;
  logic [1:0]  done_slot;

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] bg [4];
  logic [31:0] bs [4];
  int bh [4], bw [4], bst [4], be [4], bp [4];

  always #2 clk = ~clk;

  tile_agen u_tile_agen (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_field(cfg_field),
    .cfg_wdata(cfg_wdata), .go_valid(go_valid), .go_slot(go_slot), .req_valid(req_valid),
    .req_ready(req_ready), .req_gaddr(req_gaddr), .req_saddr(req_saddr), .req_bytes(req_bytes),
    .done_pulse(done_pulse), .done_slot(done_slot), .err_flag(err_flag)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int chunk_len(int rowb, int off);
    return (rowb - off > 128) ? 128 : rowb - off;
  endfunction

  task automatic cfg_write(input int s, input int f, input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_slot = 2'(s); cfg_field = 3'(f); cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // R2: field codes 0..6 per the requirement
  task automatic load(input int s, input logic [31:0] g, input logic [31:0] sa,
                      input int h, input int w, input int st, input int e, input int p);
    bg[s] = g; bs[s] = sa; bh[s] = h; bw[s] = w; bst[s] = st; be[s] = e; bp[s] = p;
    cfg_write(s, 0, g);  cfg_write(s, 1, sa); cfg_write(s, 2, 32'(h));
    cfg_write(s, 3, 32'(w)); cfg_write(s, 4, 32'(st)); cfg_write(s, 5, 32'(e));
    cfg_write(s, 6, 32'(p));
  endtask

  task automatic run_tile(input int s, input bit inject);
    int esz = 1 << be[s];
    int rowb = bw[s] * esz;
    logic [31:0] gstep = 32'(bst[s] * esz);
    logic [31:0] pitch = 32'((bw[s] + bp[s]) * esz);
    int row = 0;
    int off = 0;
    int guard = 0;
    bit first = 1'b1;
    logic [31:0] newg = 32'h0;
    logic [31:0] eg, es;
    int eb;
    bit rdy;
    @(negedge clk);
    go_valid = 1'b1; go_slot = 2'(s); req_ready = 1'b0;
    @(negedge clk);
    go_valid = 1'b0;
    if (bh[s] == 0 || bw[s] == 0) begin
      chk(done_pulse === 1'b1, "R11", "done on empty", 32'(done_pulse), 1);
      chk(done_slot === 2'(s), "R11", "done slot", 32'(done_slot), 32'(s));
      chk(req_valid === 1'b0, "R11", "no request", 32'(req_valid), 0);
      @(negedge clk);
      chk(done_pulse === 1'b0, "R8", "pulse width", 32'(done_pulse), 0);
      return;
    end
    while (guard < 20000) begin
      guard++;
      eg = bg[s] + 32'(row) * gstep + 32'(off);
      es = bs[s] + 32'(row) * pitch + 32'(off);
      eb = chunk_len(rowb, off);
      // R3 R4 R5 R6 R7: every offered cycle, including stalls, must match
      chk(req_valid === 1'b1, "R4", "valid", 32'(req_valid), 1);
      chk(req_gaddr === eg, (row > 0) ? "R5" : "R3", "gaddr", req_gaddr, eg);
      chk(req_saddr === es, (bp[s] != 0) ? "R6" : "R5", "saddr", req_saddr, es);
      chk(req_bytes === 8'(eb), "R4", "bytes", 32'(req_bytes), 32'(eb));
      chk(done_pulse === 1'b0, "R8", "early done", 32'(done_pulse), 0);
      rdy = ($urandom % 4) != 0;
      if (inject && first) begin
        newg = 32'h00AB_0000 + 32'($urandom % 4096);
        go_valid = 1'b1; go_slot = 2'(s + 1);
        cfg_we = 1'b1; cfg_slot = 2'(s); cfg_field = 3'd0; cfg_wdata = newg;
      end
      req_ready = rdy;
      @(negedge clk);
      go_valid = 1'b0; cfg_we = 1'b0;
      if (inject && first)
        chk(err_flag === 1'b1, "R9", "err set", 32'(err_flag), 1);
      first = 1'b0;
      if (rdy) begin
        off += eb;
        if (off == rowb) begin
          off = 0;
          row++;
          if (row == bh[s]) begin
            req_ready = 1'b0;
            chk(done_pulse === 1'b1, "R8", "done", 32'(done_pulse), 1);
            chk(done_slot === 2'(s), "R8", "done slot", 32'(done_slot), 32'(s));
            chk(req_valid === 1'b0, "R8", "idle at done", 32'(req_valid), 0);
            break;
          end
        end
      end
    end
    @(negedge clk);
    chk(done_pulse === 1'b0, "R8", "pulse width", 32'(done_pulse), 0);
    // R9: the dropped ignite must not start a second walk
    chk(req_valid === 1'b0, "R9", "no extra walk", 32'(req_valid), 0);
    if (inject) bg[s] = newg; // R10: takes effect on the next ignite only
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1
    chk(req_valid === 1'b0, "R1", "valid in reset", 32'(req_valid), 0);
    chk(done_pulse === 1'b0, "R1", "done in reset", 32'(done_pulse), 0);
    chk(err_flag === 1'b0, "R1", "err in reset", 32'(err_flag), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_valid === 1'b0, "R1", "valid after reset", 32'(req_valid), 0);

    // R2 R3 R4: 64 floats per row -> 0x1020/0x20 then 0x10A0/0xA0
    load(0, 32'h1020, 32'h20, 2, 64, 100, 2, 0);
    run_tile(0, 1'b0);
    // R4 R6: 33 floats -> 128 + 4 bytes per row, padded pitch, mid-walk ignite (R9, R10)
    load(1, 32'h4000, 32'h100, 3, 33, 40, 2, 1);
    run_tile(1, 1'b1);
    // R10: new global base used now
    run_tile(1, 1'b0);
    chk(err_flag === 1'b1, "R9", "err sticky", 32'(err_flag), 1);
    // R4: exact multiple, 8-byte elements
    load(2, 32'h8000, 32'h0, 2, 32, 32, 3, 1);
    run_tile(2, 1'b0);
    // R11
    load(3, 32'h9000, 32'h0, 0, 10, 10, 2, 0);
    run_tile(3, 1'b0);
    load(3, 32'h9000, 32'h0, 3, 0, 10, 2, 0);
    run_tile(3, 1'b0);

    for (int i = 0; i < 40; i++) begin
      int s = int'($urandom % 4);
      int w = 1 + int'($urandom % 70);
      load(s, $urandom, 32'($urandom % 65536), 1 + int'($urandom % 5), w,
           w + int'($urandom % 40), int'($urandom % 4), int'($urandom % 2));
      run_tile(s, 1'b0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule